// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the serial command decoder of a byte-addressed nonvolatile memory and its storage array. When a write transaction opens, it latches the start address. It then collects incoming data bytes into a page-sized staging buffer. The offset inside the page advances after each byte and wraps at the page end, so the page bits never change and a long burst overwrites the bytes loaded earlier. Each staged byte carries a keep flag that comes from the protection qualifier presented with the byte. Only locations that were loaded and permitted are written to the array.

The transaction closes on a chip-select rise event. If the decoder reports that a whole number of bytes arrived and at least one data byte was loaded, the block enters a self-timed programming period. During this period it scans the page in ascending offset order and pulses the array write port for every kept location. A ready/busy flag stays high for a fixed number of clock cycles, set by a parameter. Any other close discards the buffer. At the end of the period a one-cycle completion pulse is issued, which the surrounding logic uses to clear its write-enable latch.

The controller has five named states:
- Idle: waits for a start strobe. Start goes to Load.
- Load: stages bytes. A close with whole bytes and at least one byte goes to Commit. Any other close goes back to Idle.
- Commit: scans the page. After the last offset it goes to Wait.
- Wait: holds busy. When the timer expires it goes to Done.
- Done: issues the completion pulse, then always returns to Idle.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, busy, wr_done and arr_we are all 0.
- R2: A byte strobed in the Load state is stored at the current page offset, and the offset then increments. Offset means the low log2(PAGE_BYTES) address bits, which are 6 bits by default. In Commit, each kept byte is written once to the array at address {page bits of the start address, offset} with its data.
- R3: Once the offset passes PAGE_BYTES-1 it wraps to 0 within the same page. A later byte at an already loaded offset replaces the earlier byte, and only the last value is written.
- R4: A commit starts only when cs_rise arrives in Load with cs_whole=1 and at least one byte loaded. A byte strobed in the same cycle as cs_rise counts as loaded. Any other close (cs_whole=0, or no bytes) discards the buffer: no array write and no busy.
- R5: A byte strobed with byte_ok=0 is marked not kept and is never written to the array.
- R6: busy rises in the cycle after the accepted cs_rise and stays high for exactly WC_CYCLES consecutive cycles. WC_CYCLES must exceed PAGE_BYTES.
- R7: Array writes occur only while busy is high, with offsets strictly ascending within one commit.
- R8: wr_done is a single-cycle pulse in the first cycle after busy falls.
- R9: While busy, start_vld, byte_vld and cs_rise are ignored. The commit in progress writes only its own bytes, and no second commit follows.
- R10: A cs_rise in Idle, with no open transaction, causes no busy and no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Opens a write transaction (Idle only) |
| start_addr | input | ADDR_W | Start address of the transaction |
| byte_vld | input | 1 | One data byte is complete |
| byte_data | input | 8 | Data byte |
| byte_ok | input | 1 | Protection qualifier for this byte (1 = writable) |
| cs_rise | input | 1 | Chip-select rise event closing the transaction |
| cs_whole | input | 1 | Bit count at close was a multiple of 8 |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |
| wr_done | output | 1 | One-cycle pulse at the end of the write cycle |

## Verification
Two events can land on the same clock edge: the last byte strobe and the chip-select rise that closes the transaction. When they coincide, the final byte must be staged and committed, and it alone decides whether the close is accepted. The bench provokes this by driving both strobes together. It does this in directed cases, including a one-byte transaction where that byte is the only evidence of data, and in random transactions. The captured array writes are compared with the bench's own page model, which includes that final byte.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COMMIT,
        ST_WAIT,
        ST_DONE
    } pg_state_e;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_ofs,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          wr_keep,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_ofs,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_keep
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic [DATA_W-1:0]     data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] keep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (clr)
                    keep_q[i] <= 1'b0;
                else if (wr_en && wr_ofs == OFS_W'(i))
                    keep_q[i] <= wr_keep;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (wr_en && wr_ofs == OFS_W'(i))
                data_q[i] <= wr_data;
        end
    end

    assign rd_data = data_q[rd_ofs];
    assign rd_keep = keep_q[rd_ofs];
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
    parameter int WC_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(WC_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CW'(WC_CYCLES - 1));
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              byte_ok,
    input  logic              cs_rise,
    input  logic              cs_whole,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              busy,
    output logic              wr_done
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;

    pg_state_e        state_q, state_d;
    logic [PG_W-1:0]  page_q;
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] scan_q;
    logic             any_q;
    logic             load_en;
    logic             open_en;
    logic             expire;
    logic [7:0]       rd_data;
    logic             rd_keep;

    assign open_en = (state_q == ST_IDLE) && start_vld;
    assign load_en = (state_q == ST_LOAD) && byte_vld;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_vld) state_d = ST_LOAD;
            ST_LOAD:   if (cs_rise)
                           state_d = (cs_whole && (any_q || byte_vld)) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: if (scan_q == OFS_W'(PAGE_BYTES - 1)) state_d = ST_WAIT;
            ST_WAIT:   if (expire) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // address and scan registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
            any_q  <= 1'b0;
            scan_q <= '0;
        end else begin
            if (open_en) begin
                page_q <= start_addr[ADDR_W-1:OFS_W];
                ofs_q  <= start_addr[OFS_W-1:0];
                any_q  <= 1'b0;
            end else if (load_en) begin
                ofs_q  <= ofs_q + 1'b1;
                any_q  <= 1'b1;
            end
            scan_q <= (state_q == ST_COMMIT) ? scan_q + 1'b1 : '0;
        end
    end

    pgbuf_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (8)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (open_en),
        .wr_en   (load_en),
        .wr_ofs  (ofs_q),
        .wr_data (byte_data),
        .wr_keep (byte_ok),
        .rd_ofs  (scan_q),
        .rd_data (rd_data),
        .rd_keep (rd_keep)
    );

    pgbuf_timer #(
        .WC_CYCLES (WC_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .expire (expire)
    );

    // outputs
    always_comb begin
        busy      = 1'b0;
        wr_done   = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = {page_q, scan_q};
        arr_wdata = rd_data;
        unique case (state_q)
            ST_COMMIT: begin
                busy   = 1'b1;
                arr_we = rd_keep;
            end
            ST_WAIT:   busy    = 1'b1;
            ST_DONE:   wr_done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
    parameter int ADDR_W    = 15,
    parameter int WC_CYCLES = 250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              busy,
    input logic              wr_done,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    localparam int CW = $clog2(WC_CYCLES + 2);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= busy ? run_q + 1'b1 : '0;
    end

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == CW'(WC_CYCLES));

    // R7
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R7
    we_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> arr_addr > $past(arr_addr));

    // R8
    done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ($past(busy) && !busy));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
    .ADDR_W    (ADDR_W),
    .WC_CYCLES (WC_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_rise  (cs_rise),
    .busy     (busy),
    .wr_done  (wr_done),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/tb_pgbuf_commit.sv
`timescale 1ns/1ps
module tb_pgbuf_commit;
    localparam int AW   = 15;
    localparam int PG   = 64;
    localparam int WC   = 100;
    localparam int TCLK = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_vld = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          byte_ok = 1'b0;
    logic          cs_rise = 1'b0;
    logic          cs_whole = 1'b0;
    logic          arr_we, busy, wr_done;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;

    always #(TCLK/2) clk = ~clk;

    pgbuf_commit #(.ADDR_W(AW), .PAGE_BYTES(PG), .WC_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_ok(byte_ok),
        .cs_rise(cs_rise), .cs_whole(cs_whole), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy), .wr_done(wr_done));

    int n_chk = 0;
    int n_fail = 0;

    // capture of port activity
    logic [AW-1:0] cap_addr [128];
    logic [7:0]    cap_data [128];
    int cap_n, busy_cnt, done_cnt;

    always @(negedge clk) begin
        if (arr_we) begin
            if (cap_n < 128) begin
                cap_addr[cap_n] = arr_addr;
                cap_data[cap_n] = arr_wdata;
            end
            cap_n++;
        end
        if (busy) busy_cnt++;
        if (wr_done) done_cnt++;
    end

    // bench page model
    logic [7:0]    m_data [PG];
    bit            m_keep [PG];
    logic [AW-1:0] m_base;
    bit            exp_commit;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_cap();
        cap_n = 0; busy_cnt = 0; done_cnt = 0;
    endtask

    task automatic drv_start(input logic [AW-1:0] a);
        start_vld = 1'b1; start_addr = a;
        @(negedge clk);
        start_vld = 1'b0;
    endtask

    task automatic drv_byte(input logic [7:0] d, input bit ok, input bit with_cs, input bit whole);
        byte_vld = 1'b1; byte_data = d; byte_ok = ok;
        cs_rise = with_cs; cs_whole = whole;
        @(negedge clk);
        byte_vld = 1'b0; cs_rise = 1'b0; cs_whole = 1'b0;
    endtask

    task automatic drv_cs(input bit whole);
        cs_rise = 1'b1; cs_whole = whole;
        @(negedge clk);
        cs_rise = 1'b0; cs_whole = 1'b0;
    endtask

    // mode: 0 all writable, 1 random protection, 2 all protected
    task automatic load_txn(input logic [AW-1:0] a, input int n, input bit whole,
                            input int mode, input bit merge);
        int ofs;
        clear_cap();
        for (int i = 0; i < PG; i++) m_keep[i] = 0;
        m_base = {a[AW-1:6], 6'd0};
        ofs = int'(a[5:0]);
        drv_start(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            bit k;
            d = 8'($urandom);
            k = (mode == 0) ? 1'b1 : (mode == 2) ? 1'b0 : (($urandom % 4) != 0);
            drv_byte(d, k, merge && (i == n - 1), whole);
            m_data[ofs] = d;
            m_keep[ofs] = k;
            ofs = (ofs + 1) % PG;
        end
        if (!(merge && n > 0)) drv_cs(whole);
        exp_commit = whole && (n > 0);
    endtask

    task automatic expect_result(input string tag);
        int en, mism, guard;
        if (exp_commit) begin
            guard = 0;
            while (done_cnt == 0 && guard < WC + 200) begin
                @(negedge clk); guard++;
            end
            repeat (5) @(negedge clk);
        end else begin
            repeat (8) @(negedge clk);
        end
        en = 0; mism = 0;
        for (int o = 0; o < PG; o++) begin
            if (exp_commit && m_keep[o]) begin
                if (en >= cap_n || en >= 128 ||
                    cap_addr[en] != (m_base | AW'(o)) || cap_data[en] != m_data[o])
                    mism++;
                en++;
            end
        end
        chk(cap_n == en, {tag, " R2 R5 write count"}, cap_n, en);
        chk(mism == 0, {tag, " R2 R3 write content"}, mism, 0);
        chk(busy_cnt == (exp_commit ? WC : 0), {tag, " R6 R4 busy length"}, busy_cnt,
            exp_commit ? WC : 0);
        chk(done_cnt == (exp_commit ? 1 : 0), {tag, " R8 done pulses"}, done_cnt,
            exp_commit ? 1 : 0);
    endtask

    initial begin
        #(TCLK * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_cap();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(wr_done == 1'b0, "R1 wr_done", wr_done, 0);
        chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 single byte, then full page
        load_txn(15'h0123, 1, 1, 0, 0);  expect_result("single");
        load_txn(15'h2A40, 64, 1, 0, 0); expect_result("full page");
        // R3 wrap with overwrite
        load_txn(15'h7FFA, 70, 1, 0, 0); expect_result("wrap R3");
        // R4 partial byte and no bytes
        load_txn(15'h0100, 5, 0, 0, 0);  expect_result("partial R4");
        load_txn(15'h0200, 0, 1, 0, 0);  expect_result("empty R4");
        // R4 last byte together with cs rise
        load_txn(15'h0300, 1, 1, 0, 1);  expect_result("merge one R4");
        load_txn(15'h033E, 4, 1, 1, 1);  expect_result("merge wrap R4");
        // R5 protection
        load_txn(15'h4000, 10, 1, 2, 0); expect_result("all protected R5");
        load_txn(15'h4410, 30, 1, 1, 0); expect_result("mixed R5");

        // R9 activity during busy is ignored
        load_txn(15'h1230, 6, 1, 0, 0);
        repeat (10) @(negedge clk);
        drv_start(15'h1200);
        drv_byte(8'hA5, 1'b1, 1'b0, 1'b1);
        drv_byte(8'h5A, 1'b1, 1'b0, 1'b1);
        drv_cs(1'b1);
        expect_result("busy ignore R9");

        // R10 cs rise with nothing open
        clear_cap();
        drv_cs(1'b1);
        repeat (8) @(negedge clk);
        chk(busy_cnt == 0, "R10 idle close busy", busy_cnt, 0);
        chk(cap_n == 0, "R10 idle close writes", cap_n, 0);

        // random transactions
        for (int t = 0; t < 20; t++) begin
            logic [AW-1:0] a;
            int n;
            bit w, mg;
            a  = AW'($urandom);
            n  = int'($urandom % 81);
            w  = ($urandom % 5) != 0;
            mg = ($urandom % 3) == 0;
            load_txn(a, n, w, 1, mg);
            expect_result("random R2 R3 R4 R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule